// File: doc/BRIEF.md
# FPGA Configuration Handshake Controller

This block sits on the host side of a slave FPGA and runs the configuration handshake around a serial bitstream download. After a start pulse it pulls the active-low program line down and holds it there for a minimum width. It releases the line only after it sees the target's init line low. It then waits for init to come back high, which means the target's configuration memory is clear, and lets a settling interval pass. After that it raises a shift enable for an external serial shifter.

While the shift enable is high, the controller watches the done and init lines and the shifter's busy flag. Done going high ends the sequence with success. Init dropping low is a failure at once. Done staying low for a long window after the shifter goes idle is also a failure. On a failure the whole sequence starts again from the program pulse, up to a set number of retries. After that a sticky error is raised. All intervals are counted in clock cycles and set by parameters, so a simulation can use short values.

Top module: `cfg_hs_ctrl`

## Requirements
- R1: After reset, program_n is 1, shift_enable is 0, success is 0, error is 0 and attempt is 0.
- R2: A start pulse seen while the controller is idle, successful or in error clears success and error. In the next cycle it drives program_n to 0 and sets attempt to 1.
- R3: Once driven low, program_n stays 0 for at least PROG_PULSE cycles and until init_n has been sampled 0. It rises in the cycle after both hold.
- R4: After program_n rises, shift_enable stays 0 while init_n is 0. Once init_n is sampled 1, shift_enable rises after a further SETTLE_CYC cycles. shift_enable is never 1 while program_n is 0.
- R5: While shift_enable is 1, a sampled done of 1 ends the attempt. In the next cycle success is 1, shift_enable is 0 and program_n is 1.
- R6: While shift_enable is 1 and done is 0, a sampled init_n of 0 fails the attempt. In the next cycle program_n is 0 and attempt has grown by one, unless retries are used up.
- R7: Once xfer_busy is 0, the attempt fails if done stays 0 for DONE_TIMEOUT cycles. shift_enable is high for exactly that many cycles when xfer_busy is held 0. Cycles with xfer_busy at 1 do not count toward the timeout.
- R8: After a failed attempt number MAX_RETRIES+1, error becomes 1, program_n is 1, shift_enable is 0 and attempt keeps the value MAX_RETRIES+1. attempt never exceeds MAX_RETRIES+1.
- R9: success and error are never 1 together. Each holds, whatever init_n, done and xfer_busy do, until reset or a start pulse.
- R10: A start pulse while a sequence is running has no effect: program_n, shift_enable and attempt continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin a configuration sequence |
| init_n | input | 1 | Target's init line (low: busy clearing or error) |
| done | input | 1 | Target's done line (high: configured) |
| xfer_busy | input | 1 | High while the external shifter is still sending the bitstream |
| program_n | output | 1 | Active-low program line to the target |
| shift_enable | output | 1 | Allows the external shifter to send data |
| success | output | 1 | Sticky: configuration finished with done high |
| error | output | 1 | Sticky: every permitted attempt failed |
| attempt | output | $clog2(MAX_RETRIES+2) | Current or last attempt number, 1-based; 0 after reset |

## Verification
Several properties are checked on every cycle. success and error never overlap and each one holds until a start pulse. The shift enable never overlaps a low program line. Every low program pulse lasts at least the minimum width. Done seen in the data phase always yields success. Init dropping in the data phase always yields a new pulse or the error, and the attempt count stays in range. Whether the settle interval and the timeout have the exact length in cycles, whether a busy shifter truly pauses the timeout, and whether start is ignored mid-sequence can only be shown by the bench's scenarios. Those scenarios count cycles against the parameters and drive the target lines as a slave would.

// File: rtl/cfg_hs_pkg.sv
package cfg_hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_PULSE     = 3'd1,
    ST_WAIT_INIT = 3'd2,
    ST_SETTLE    = 3'd3,
    ST_DATA      = 3'd4,
    ST_OK        = 3'd5,
    ST_ERR       = 3'd6
  } cfg_state_e;

endpackage

// File: rtl/cfg_hs_rst_sync.sv
module cfg_hs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/cfg_hs_timer.sv
module cfg_hs_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | dec;
    if (load) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - {{(WIDTH-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/cfg_hs_attempts.sv
module cfg_hs_attempts #(
  parameter int MAX_ATT = 4,
  localparam int AW     = $clog2(MAX_ATT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          inc,
  output logic [AW-1:0] count,
  output logic          last
);

  localparam logic [AW-1:0] ONE_V  = AW'(1);
  localparam logic [AW-1:0] LAST_V = AW'(MAX_ATT);

  logic [AW-1:0] cnt_q;
  logic [AW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear | inc;
    if (clear) begin
      cnt_d = ONE_V;
    end else begin
      cnt_d = cnt_q + ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
  assign last  = (cnt_q == LAST_V);

endmodule

// File: rtl/cfg_hs_fsm.sv
module cfg_hs_fsm
  import cfg_hs_pkg::*;
#(
  parameter int TW         = 8,
  parameter int PULSE_LEN  = 4,
  parameter int SETTLE_LEN = 4,
  parameter int WAIT_LEN   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          init_n,
  input  logic          done,
  input  logic          xfer_busy,
  input  logic          tmr_zero,
  input  logic          last_att,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          tmr_dec,
  output logic          att_clear,
  output logic          att_inc,
  output logic          program_n,
  output logic          shift_enable,
  output logic          success,
  output logic          error
);

  localparam logic [TW-1:0] PULSE_V  = TW'(PULSE_LEN - 1);
  localparam logic [TW-1:0] SETTLE_V = TW'(SETTLE_LEN - 1);
  localparam logic [TW-1:0] WAIT_V   = TW'(WAIT_LEN - 1);

  cfg_state_e state_q;
  cfg_state_e state_d;
  logic       fail;

  // next-state and control decode
  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    tmr_dec   = 1'b0;
    att_clear = 1'b0;
    att_inc   = 1'b0;
    fail      = 1'b0;
    case (state_q)
      ST_IDLE, ST_OK, ST_ERR: begin
        if (start) begin
          state_d   = ST_PULSE;
          tmr_load  = 1'b1;
          tmr_val   = PULSE_V;
          att_clear = 1'b1;
        end
      end
      ST_PULSE: begin
        if (!tmr_zero) begin
          tmr_dec = 1'b1;
        end else if (!init_n) begin
          state_d = ST_WAIT_INIT;
        end
      end
      ST_WAIT_INIT: begin
        if (init_n) begin
          state_d  = ST_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_V;
        end
      end
      ST_SETTLE: begin
        if (!tmr_zero) begin
          tmr_dec = 1'b1;
        end else begin
          state_d  = ST_DATA;
          tmr_load = 1'b1;
          tmr_val  = WAIT_V;
        end
      end
      ST_DATA: begin
        if (done) begin
          state_d = ST_OK;
        end else if (!init_n) begin
          fail = 1'b1;
        end else if (!xfer_busy) begin
          if (tmr_zero) begin
            fail = 1'b1;
          end else begin
            tmr_dec = 1'b1;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase

    if (fail) begin
      if (last_att) begin
        state_d = ST_ERR;
      end else begin
        state_d  = ST_PULSE;
        tmr_load = 1'b1;
        tmr_val  = PULSE_V;
        att_inc  = 1'b1;
      end
    end
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // output decode from the registered state
  always_comb begin
    program_n    = (state_q != ST_PULSE);
    shift_enable = (state_q == ST_DATA);
    success      = (state_q == ST_OK);
    error        = (state_q == ST_ERR);
  end

endmodule

// File: rtl/cfg_hs_ctrl.sv
module cfg_hs_ctrl #(
  parameter int PROG_PULSE   = 25,
  parameter int SETTLE_CYC   = 2500,
  parameter int DONE_TIMEOUT = 300000,
  parameter int MAX_RETRIES  = 3,
  localparam int MAX_ATT     = MAX_RETRIES + 1,
  localparam int AW          = $clog2(MAX_ATT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          init_n,
  input  logic          done,
  input  logic          xfer_busy,
  output logic          program_n,
  output logic          shift_enable,
  output logic          success,
  output logic          error,
  output logic [AW-1:0] attempt
);

  localparam int MAXV_A = (PROG_PULSE > SETTLE_CYC) ? PROG_PULSE : SETTLE_CYC;
  localparam int MAXV   = (MAXV_A > DONE_TIMEOUT) ? MAXV_A : DONE_TIMEOUT;
  localparam int TW     = $clog2(MAXV + 1);

  logic          srst_n;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_dec;
  logic          tmr_zero;
  logic          att_clear;
  logic          att_inc;
  logic          last_att;

  cfg_hs_rst_sync #(
    .STAGES(2)
  ) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cfg_hs_timer #(
    .WIDTH(TW)
  ) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  cfg_hs_attempts #(
    .MAX_ATT(MAX_ATT)
  ) u_att (
    .clk   (clk),
    .rst_n (srst_n),
    .clear (att_clear),
    .inc   (att_inc),
    .count (attempt),
    .last  (last_att)
  );

  cfg_hs_fsm #(
    .TW         (TW),
    .PULSE_LEN  (PROG_PULSE),
    .SETTLE_LEN (SETTLE_CYC),
    .WAIT_LEN   (DONE_TIMEOUT)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (srst_n),
    .start        (start),
    .init_n       (init_n),
    .done         (done),
    .xfer_busy    (xfer_busy),
    .tmr_zero     (tmr_zero),
    .last_att     (last_att),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .tmr_dec      (tmr_dec),
    .att_clear    (att_clear),
    .att_inc      (att_inc),
    .program_n    (program_n),
    .shift_enable (shift_enable),
    .success      (success),
    .error        (error)
  );

endmodule

// File: rtl/cfg_hs_ctrl_chk.sv
module cfg_hs_ctrl_chk #(
  parameter int PROG_PULSE  = 25,
  parameter int MAX_RETRIES = 3,
  localparam int MAX_ATT    = MAX_RETRIES + 1,
  localparam int AW         = $clog2(MAX_ATT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          init_n,
  input logic          done,
  input logic          xfer_busy,
  input logic          program_n,
  input logic          shift_enable,
  input logic          success,
  input logic          error,
  input logic [AW-1:0] attempt
);

  localparam logic [AW-1:0] MAX_ATT_V = AW'(MAX_ATT);
  localparam logic [15:0]   PULSE_V   = 16'(PROG_PULSE);

  // length of the current run of low program cycles, saturating
  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (program_n) begin
      low_run <= '0;
    end else if (low_run != 16'hFFFF) begin
      low_run <= low_run + 16'd1;
    end
  end

  // R3: a program pulse ends only after its minimum width
  a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    (program_n && !$past(program_n)) |-> (low_run >= PULSE_V));

  // R4: data phase never overlaps a low program line
  a_r4_shift_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
    shift_enable |-> program_n);

  // R5: done seen in the data phase gives success
  a_r5_done_success: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_enable && done) |=> (success && !shift_enable));

  // R6: init low in the data phase fails the attempt
  a_r6_init_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_enable && !done && !init_n) |=>
      (error || (!program_n && attempt == $past(attempt) + AW'(1))));

  // R7: a busy shifter keeps the data phase open
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_enable && xfer_busy && !done && init_n) |=> shift_enable);

  // R8: attempt count bounded
  a_r8_attempt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    attempt <= MAX_ATT_V);

  // R9: sticky and exclusive results
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(success && error));

  a_r9_success_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (success && !start) |=> success);

  a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);

  // R2: start after a finished sequence restarts at attempt one
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ((success || error) && start) |=>
      (!program_n && !success && !error && attempt == AW'(1)));

endmodule

bind cfg_hs_ctrl cfg_hs_ctrl_chk #(
  .PROG_PULSE  (PROG_PULSE),
  .MAX_RETRIES (MAX_RETRIES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .init_n       (init_n),
  .done         (done),
  .xfer_busy    (xfer_busy),
  .program_n    (program_n),
  .shift_enable (shift_enable),
  .success      (success),
  .error        (error),
  .attempt      (attempt)
);

// File: tb/cfg_hs_ctrl_test.sv
module cfg_hs_ctrl_test;

  localparam int P  = 4;
  localparam int S  = 5;
  localparam int T  = 20;
  localparam int MR = 3;
  localparam int AW = $clog2(MR + 2);

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          init_n;
  logic          done;
  logic          xfer_busy;
  logic          program_n;
  logic          shift_enable;
  logic          success;
  logic          error;
  logic [AW-1:0] attempt;

  int checks;
  int fails;

  cfg_hs_ctrl #(
    .PROG_PULSE   (P),
    .SETTLE_CYC   (S),
    .DONE_TIMEOUT (T),
    .MAX_RETRIES  (MR)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .init_n       (init_n),
    .done         (done),
    .xfer_busy    (xfer_busy),
    .program_n    (program_n),
    .shift_enable (shift_enable),
    .success      (success),
    .error        (error),
    .attempt      (attempt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // slave side: answer a low program line and bring the controller to the data phase
  task automatic slave_to_data();
    int n;
    init_n = 1'b0;
    n = 0;
    while (!program_n && n < 1000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    init_n = 1'b1;
    n = 0;
    while (!shift_enable && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "program_n", program_n, 1);
    chk("R1", "shift_enable", shift_enable, 0);
    chk("R1", "success", success, 0);
    chk("R1", "error", error, 0);
    chk("R1", "attempt", attempt, 0);
  endtask

  task automatic t_success_path();
    int n;
    int bad;
    pulse_start();
    chk("R2", "program_n after start", program_n, 0);
    chk("R2", "attempt after start", attempt, 1);
    // init_n still high: program must stay low past the minimum width
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (program_n) bad++;
    end
    chk("R3", "program_n released before init_n low", bad, 0);
    init_n = 1'b0;
    n = 0;
    while (!program_n && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk("R3", "cycles to release after init_n low", n, 1);
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (shift_enable) bad++;
    end
    chk("R4", "shift_enable while init_n low", bad, 0);
    init_n    = 1'b1;
    xfer_busy = 1'b1;
    n = 0;
    while (!shift_enable && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk("R4", "cycles init_n high to shift_enable", n, S + 1);
    bad = 0;
    for (int i = 0; i < T + 10; i++) begin
      @(negedge clk);
      if (!shift_enable || !program_n) bad++;
    end
    chk("R7", "timeout advanced while busy", bad, 0);
    xfer_busy = 1'b0;
    repeat (5) @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    chk("R5", "success after done", success, 1);
    chk("R5", "shift_enable after done", shift_enable, 0);
    chk("R5", "program_n after done", program_n, 1);
    chk("R5", "attempt after done", attempt, 1);
    // R9: success holds while the target lines move
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      done      = i[0];
      init_n    = i[1];
      xfer_busy = i[0];
      @(negedge clk);
      if (!success || error) bad++;
    end
    chk("R9", "success sticky", bad, 0);
    done      = 1'b0;
    init_n    = 1'b1;
    xfer_busy = 1'b0;
  endtask

  task automatic t_init_fail();
    int n;
    pulse_start();
    chk("R9", "success cleared by start", success, 0);
    init_n = 1'b0;
    n = 0;
    while (!program_n && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk("R3", "minimum pulse width", n, P);
    @(negedge clk);
    init_n = 1'b1;
    n = 0;
    while (!shift_enable && n < 1000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    init_n = 1'b0;
    @(negedge clk);
    chk("R6", "program_n after init_n low", program_n, 0);
    chk("R6", "attempt after init_n low", attempt, 2);
    chk("R6", "shift_enable after init_n low", shift_enable, 0);
    slave_to_data();
    done = 1'b1;
    @(negedge clk);
    chk("R5", "success on retry", success, 1);
    chk("R5", "attempt on retry", attempt, 2);
    done = 1'b0;
  endtask

  task automatic t_exhaust();
    int n;
    int bad;
    pulse_start();
    for (int a = 1; a <= MR + 1; a++) begin
      slave_to_data();
      chk("R8", "attempt index", attempt, a);
      n = 0;
      while (shift_enable && n < 1000) begin
        n++;
        @(negedge clk);
      end
      chk("R7", "data phase length without done", n, T);
    end
    chk("R8", "error after last attempt", error, 1);
    chk("R8", "program_n in error", program_n, 1);
    chk("R8", "shift_enable in error", shift_enable, 0);
    chk("R8", "attempt kept", attempt, MR + 1);
    chk("R9", "success in error", success, 0);
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      done   = i[0];
      init_n = i[1];
      @(negedge clk);
      if (!error || success || !program_n) bad++;
    end
    chk("R9", "error sticky", bad, 0);
    done   = 1'b0;
    init_n = 1'b1;
    pulse_start();
    chk("R2", "error cleared by start", error, 0);
    chk("R2", "program_n after restart", program_n, 0);
    chk("R2", "attempt after restart", attempt, 1);
    slave_to_data();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic t_start_ignored();
    int n;
    pulse_start();
    init_n = 1'b0;
    n = 0;
    while (!program_n && n < 1000) begin
      @(negedge clk);
      n++;
    end
    pulse_start();
    chk("R10", "program_n after start while waiting", program_n, 1);
    chk("R10", "attempt after start while waiting", attempt, 1);
    init_n    = 1'b1;
    xfer_busy = 1'b1;
    n = 0;
    while (!shift_enable && n < 1000) begin
      @(negedge clk);
      n++;
    end
    pulse_start();
    chk("R10", "shift_enable after start in data phase", shift_enable, 1);
    chk("R10", "attempt after start in data phase", attempt, 1);
    xfer_busy = 1'b0;
    done      = 1'b1;
    @(negedge clk);
    chk("R5", "success after ignored starts", success, 1);
    done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks    = 0;
    fails     = 0;
    start     = 1'b0;
    init_n    = 1'b1;
    done      = 1'b0;
    xfer_busy = 1'b0;
    rst_n     = 1'b0;
    t_reset();
    t_success_path();
    t_init_fail();
    t_exhaust();
    t_start_ignored();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule